// File: doc/BRIEF.md
# Eight-Channel DMA Register Front End

This block holds the software-visible programming registers of an eight-channel DMA engine. The engine is split into two four-channel controllers. Channels 0 to 3 move bytes, and channels 4 to 7 move 16-bit words. A host programs the block through an 8-bit I/O port with write and read strobes. The block decodes each controller's address, count, mask, mode and pointer-clear registers. It also decodes a separately addressed page port for every channel.

For each channel the block presents three values to a transfer sequencer: the full physical start address, the transfer length in bytes, and the direction. The sequencer pulses a per-channel step input once per unit moved. On each step the block advances that channel's current address and count. When the count runs out, it raises terminal count and masks the channel.

The byte controller sits at `BYTE_BASE` with one-byte register spacing. The word controller sits at `WORD_BASE` with two-byte spacing.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every channel is masked, both byte pointers select the low byte, and all registers and terminal-count outputs are zero.
- R2: Register offsets inside the byte controller, relative to `BYTE_BASE`, are:
  - channel c address: 2c
  - channel c count: 2c+1
  - single mask: 10
  - mode: 11
  - pointer clear: 12
  
  The word controller, relative to `WORD_BASE`, uses twice each offset. Odd addresses in its window and all other offsets are ignored.
- R3: Each controller has its own byte pointer, which starts at the low byte. Every write or read of one of its address or count registers toggles the pointer, so a 16-bit value goes low byte first, then high byte. Any write to the clear offset returns the pointer to low.
- R4: The page ports for channels 0 to 7 are at I/O addresses 0x87, 0x83, 0x81, 0x82, 0x8F, 0x8B, 0x89 and 0x8A. Each holds 8 bits and reads back.
- R5: The physical start address (24 bits) is formed as follows. A byte channel gives {page, base address}. A word channel gives {page[7:1], base address, 0}.
- R6: The length output counts bytes. A byte channel gives count+1. A word channel gives 2*(count+1).
- R7: A single-mask write selects a channel of its controller with data bits [1:0]. Data bit 2 set masks that channel, and bit 2 clear unmasks it. `ch_enabled` is high exactly for unmasked channels.
- R8: A mode write selects a channel with data bits [1:0] and stores data bits [7:2]. Bits [3:2] = 01 mean transfer into memory, reported on `ch_to_mem`. Bits [7:6] = 11 mean cascade, reported on `ch_cascade`.
- R9: A step on an unmasked channel that is not in cascade does two things. It adds one to the channel's current address, wrapping within 16 bits with no carry into the page. It subtracts one from the current count.
- R10: A step that finds the current count at zero wraps the count to 0xFFFF. The channel's terminal-count output then pulses for exactly one cycle after that edge, and the channel is masked at the same edge. This masking overrides a mask write in the same cycle.
- R11: A step is ignored in three cases: the channel is masked, the channel is in cascade, or the same cycle writes that channel's address or count.
- R12: While `io_rd` is high, the read port returns a value chosen by the address:
  - address or count register: the byte of the current value that the pointer selects
  - page port: the page byte
  - any other address: zero
  
  While `io_rd` is low, the read port returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O register address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| xfer_step | input | 8 | Per-channel pulse: one unit moved |
| ch_phys_addr | output | 192 | Per-channel 24-bit physical start address |
| ch_len | output | 144 | Per-channel 18-bit length in bytes |
| ch_to_mem | output | 8 | Per-channel direction, 1 = into memory |
| ch_cascade | output | 8 | Per-channel cascade mode |
| ch_enabled | output | 8 | Per-channel unmasked |
| ch_tc | output | 8 | Per-channel terminal-count pulse |

## Verification
A wrong byte pointer or decode shows up at once on `ch_phys_addr` or `ch_len`: a written byte lands in the wrong half or the wrong channel, and the bench compares these outputs on every clock. A wrong current address or count stays hidden until it is read back or reaches terminal count. To expose it, the bench reads current values after stepping, drives a count through its zero wrap, and compares `ch_tc` and `ch_enabled` in the cycle after the final step. A long run of mixed random writes, reads and steps keeps the model and the design in lockstep, so any stray toggle shows up within a few cycles.

// File: rtl/dma_regs_pkg.sv
`timescale 1ns/1ps
package dma_regs_pkg;

    // decoded meaning of one I/O address
    typedef struct packed {
        logic       hit_ac;    // address or count register
        logic       hit_cnt;   // count half of hit_ac
        logic       hit_mask;
        logic       hit_mode;
        logic       hit_clr;
        logic       ctl;       // 0 = byte controller, 1 = word controller
        logic [1:0] sub;       // channel within controller
        logic       hit_page;
        logic [2:0] page_ch;
    } dec_t;

    function automatic logic [7:0] page_port(input logic [2:0] ch);
        case (ch)
            3'd0:    page_port = 8'h87;
            3'd1:    page_port = 8'h83;
            3'd2:    page_port = 8'h81;
            3'd3:    page_port = 8'h82;
            3'd4:    page_port = 8'h8F;
            3'd5:    page_port = 8'h8B;
            3'd6:    page_port = 8'h89;
            default: page_port = 8'h8A;
        endcase
    endfunction

endpackage

// File: rtl/dma_io_decode.sv
`timescale 1ns/1ps
module dma_io_decode
    import dma_regs_pkg::*;
#(
    parameter logic [7:0] BYTE_BASE = 8'h00,
    parameter logic [7:0] WORD_BASE = 8'hC0
) (
    input  logic [7:0] io_addr,
    output dec_t       dec
);
    localparam int NCH = 8;

    logic [7:0] boff, woff;
    logic       byte_hit, word_hit;
    logic [3:0] off;

    always_comb begin
        boff     = io_addr - BYTE_BASE;
        woff     = io_addr - WORD_BASE;
        byte_hit = (boff < 8'd16);
        word_hit = (woff < 8'd32) && !woff[0];
        off      = byte_hit ? boff[3:0] : woff[4:1];

        dec      = '0;
        dec.ctl  = !byte_hit;
        dec.sub  = off[2:1];
        if (byte_hit || word_hit) begin
            dec.hit_ac   = (off < 4'd8);
            dec.hit_cnt  = (off < 4'd8) && off[0];
            dec.hit_mask = (off == 4'd10);
            dec.hit_mode = (off == 4'd11);
            dec.hit_clr  = (off == 4'd12);
        end
        for (int c = 0; c < NCH; c++) begin
            if (io_addr == page_port(3'(c))) begin
                dec.hit_page = 1'b1;
                dec.page_ch  = 3'(c);
            end
        end
    end

endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan #(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic          hi_byte,
    input  logic [7:0]    wdata,
    input  logic          ld_page,
    input  logic          ld_mode,
    input  logic          ld_mask,
    input  logic          step,
    output logic [AW-1:0] base_addr,
    output logic [AW-1:0] base_cnt,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic [5:0]    mode,
    output logic          masked,
    output logic          tc
);
    localparam int HB = AW - 8;

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [AW-1:0] base_cnt;
        logic [AW-1:0] cur_addr;
        logic [AW-1:0] cur_cnt;
        logic [PW-1:0] page;
        logic [5:0]    mode;
        logic          masked;
        logic          tc;
    } st_t;

    st_t  st_d, st_q;
    logic cascade, step_ok;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        cascade = (st_q.mode[5:4] == 2'b11);
        step_ok = step && !st_q.masked && !cascade && !ld_addr && !ld_cnt;

        if (ld_addr) begin
            if (hi_byte) begin
                st_d.base_addr[AW-1:8] = wdata[HB-1:0];
                st_d.cur_addr[AW-1:8]  = wdata[HB-1:0];
            end else begin
                st_d.base_addr[7:0] = wdata;
                st_d.cur_addr[7:0]  = wdata;
            end
        end
        if (ld_cnt) begin
            if (hi_byte) begin
                st_d.base_cnt[AW-1:8] = wdata[HB-1:0];
                st_d.cur_cnt[AW-1:8]  = wdata[HB-1:0];
            end else begin
                st_d.base_cnt[7:0] = wdata;
                st_d.cur_cnt[7:0]  = wdata;
            end
        end
        if (ld_page) st_d.page   = wdata[PW-1:0];
        if (ld_mode) st_d.mode   = wdata[7:2];
        if (ld_mask) st_d.masked = wdata[2];

        if (step_ok) begin
            st_d.cur_addr = st_q.cur_addr + 1'b1;
            st_d.cur_cnt  = st_q.cur_cnt - 1'b1;
            if (st_q.cur_cnt == '0) begin
                st_d.tc     = 1'b1;
                st_d.masked = 1'b1;   // terminal count wins over a mask write
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_addr = st_q.base_addr;
    assign base_cnt  = st_q.base_cnt;
    assign cur_addr  = st_q.cur_addr;
    assign cur_cnt   = st_q.cur_cnt;
    assign page      = st_q.page;
    assign mode      = st_q.mode;
    assign masked    = st_q.masked;
    assign tc        = st_q.tc;

    // R10: a terminal-count pulse always comes with the channel masked
    p_tc_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tc |-> st_q.masked);

    // R11: a step on a masked channel leaves its count alone
    p_masked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.masked && !ld_addr && !ld_cnt) |=> $stable(st_q.cur_cnt));

    // R9: an accepted step lowers the count by one
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |=> (st_q.cur_cnt == $past(st_q.cur_cnt) - 1'b1));

endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter logic [7:0] BYTE_BASE = 8'h00,
    parameter logic [7:0] WORD_BASE = 8'hC0,
    parameter int         AW        = 16,
    parameter int         PW        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    input  logic [7:0]            xfer_step,
    output logic [8*(AW+PW)-1:0]  ch_phys_addr,
    output logic [8*(AW+2)-1:0]   ch_len,
    output logic [7:0]            ch_to_mem,
    output logic [7:0]            ch_cascade,
    output logic [7:0]            ch_enabled,
    output logic [7:0]            ch_tc
);
    localparam int NCH = 8;
    localparam int PAW = AW + PW;
    localparam int LW  = AW + 2;

    typedef struct packed {
        logic [1:0] ptr;   // byte pointer per controller
    } top_t;

    dec_t       dec;
    top_t       st_d, st_q;
    logic [2:0] ac_ch, cmd_ch;
    logic [AW-1:0] base_addr_w [NCH];
    logic [AW-1:0] base_cnt_w  [NCH];
    logic [AW-1:0] cur_addr_w  [NCH];
    logic [AW-1:0] cur_cnt_w   [NCH];
    logic [PW-1:0] page_w      [NCH];
    logic [5:0]    mode_w      [NCH];
    logic [NCH-1:0] masked_w;
    logic [AW-1:0] rd_val;

    dma_io_decode #(.BYTE_BASE(BYTE_BASE), .WORD_BASE(WORD_BASE)) u_dec (
        .io_addr (io_addr),
        .dec     (dec)
    );

    assign ac_ch  = {dec.ctl, dec.sub};
    assign cmd_ch = {dec.ctl, io_wdata[1:0]};

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < 2; k++) begin
            if (io_wr && dec.hit_clr && (dec.ctl == 1'(k)))
                st_d.ptr[k] = 1'b0;
            else if ((io_wr || io_rd) && dec.hit_ac && (dec.ctl == 1'(k)))
                st_d.ptr[k] = !st_q.ptr[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dma_chan #(.AW(AW), .PW(PW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_addr   (io_wr && dec.hit_ac && !dec.hit_cnt && (ac_ch == 3'(c))),
                .ld_cnt    (io_wr && dec.hit_cnt && (ac_ch == 3'(c))),
                .hi_byte   (st_q.ptr[dec.ctl]),
                .wdata     (io_wdata),
                .ld_page   (io_wr && dec.hit_page && (dec.page_ch == 3'(c))),
                .ld_mode   (io_wr && dec.hit_mode && (cmd_ch == 3'(c))),
                .ld_mask   (io_wr && dec.hit_mask && (cmd_ch == 3'(c))),
                .step      (xfer_step[c]),
                .base_addr (base_addr_w[c]),
                .base_cnt  (base_cnt_w[c]),
                .cur_addr  (cur_addr_w[c]),
                .cur_cnt   (cur_cnt_w[c]),
                .page      (page_w[c]),
                .mode      (mode_w[c]),
                .masked    (masked_w[c]),
                .tc        (ch_tc[c])
            );
            if (c < NCH/2) begin : g_byte
                assign ch_phys_addr[c*PAW +: PAW] = {page_w[c], base_addr_w[c]};
                assign ch_len[c*LW +: LW] = LW'({1'b0, base_cnt_w[c]} + 1'b1);
            end else begin : g_word
                assign ch_phys_addr[c*PAW +: PAW] = {page_w[c][PW-1:1], base_addr_w[c], 1'b0};
                assign ch_len[c*LW +: LW] = {({1'b0, base_cnt_w[c]} + 1'b1), 1'b0};
            end
            assign ch_to_mem[c]  = (mode_w[c][1:0] == 2'b01);
            assign ch_cascade[c] = (mode_w[c][5:4] == 2'b11);
            assign ch_enabled[c] = !masked_w[c];
        end
    endgenerate

    always_comb begin
        rd_val   = dec.hit_cnt ? cur_cnt_w[ac_ch] : cur_addr_w[ac_ch];
        io_rdata = '0;
        if (io_rd) begin
            if (dec.hit_ac)
                io_rdata = st_q.ptr[dec.ctl] ? rd_val[AW-1:8] : rd_val[7:0];
            else if (dec.hit_page)
                io_rdata = page_w[dec.page_ch];
        end
    end

    // R2: an address decodes to at most one kind of register
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec.hit_ac, dec.hit_mask, dec.hit_mode, dec.hit_clr, dec.hit_page}));

    // R3: a clear write leaves that controller's pointer on the low byte
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && dec.hit_clr) |=> (st_q.ptr[$past(dec.ctl)] == 1'b0));

endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
    localparam int BB = 'h00;
    localparam int WB = 'hC0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   io_addr = '0, io_wdata = '0, io_rdata;
    logic         io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]   xfer_step = '0;
    logic [191:0] ch_phys_addr;
    logic [143:0] ch_len;
    logic [7:0]   ch_to_mem, ch_cascade, ch_enabled, ch_tc;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_step(xfer_step),
        .ch_phys_addr(ch_phys_addr), .ch_len(ch_len), .ch_to_mem(ch_to_mem),
        .ch_cascade(ch_cascade), .ch_enabled(ch_enabled), .ch_tc(ch_tc)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_ba[8], m_bc[8], m_ca[8], m_cc[8], m_pg[8], m_md[8], m_mk[8], m_tc[8];
    int m_ptr[2];
    int pports[8] = '{'h87, 'h83, 'h81, 'h82, 'h8F, 'h8B, 'h89, 'h8A};

    // kind: 0 none, 1 addr/count, 2 mask, 3 mode, 4 clear, 5 page
    function automatic void decode(input int a, output int kind, output int ch,
                                   output int isc, output int ctl);
        int off;
        kind = 0; ch = 0; isc = 0; ctl = 0; off = -1;
        if (a >= BB && a < BB + 16) begin ctl = 0; off = a - BB; end
        else if (a >= WB && a < WB + 32 && (a % 2) == 0) begin ctl = 1; off = (a - WB) / 2; end
        if (off >= 0 && off < 8) begin kind = 1; ch = ctl * 4 + off / 2; isc = off % 2; end
        else if (off == 10) kind = 2;
        else if (off == 11) kind = 3;
        else if (off == 12) kind = 4;
        for (int i = 0; i < 8; i++) if (a == pports[i]) begin kind = 5; ch = i; end
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 8; c++) begin
            m_ba[c] = 0; m_bc[c] = 0; m_ca[c] = 0; m_cc[c] = 0;
            m_pg[c] = 0; m_md[c] = 0; m_mk[c] = 1; m_tc[c] = 0;
        end
        m_ptr[0] = 0; m_ptr[1] = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int kind, ch, isc, ctl, wd, c2;
            int om[8], omd[8], wrac[8];
            decode(int'(io_addr), kind, ch, isc, ctl);
            wd = int'(io_wdata);
            for (int c = 0; c < 8; c++) begin om[c] = m_mk[c]; omd[c] = m_md[c]; wrac[c] = 0; m_tc[c] = 0; end
            if (io_wr) begin
                c2 = ctl * 4 + (wd % 4);
                case (kind)
                    1: begin
                        wrac[ch] = 1;
                        if (isc == 0) begin
                            if (m_ptr[ctl]) begin m_ba[ch] = (m_ba[ch] % 256) + wd * 256; m_ca[ch] = (m_ca[ch] % 256) + wd * 256; end
                            else begin m_ba[ch] = (m_ba[ch] / 256) * 256 + wd; m_ca[ch] = (m_ca[ch] / 256) * 256 + wd; end
                        end else begin
                            if (m_ptr[ctl]) begin m_bc[ch] = (m_bc[ch] % 256) + wd * 256; m_cc[ch] = (m_cc[ch] % 256) + wd * 256; end
                            else begin m_bc[ch] = (m_bc[ch] / 256) * 256 + wd; m_cc[ch] = (m_cc[ch] / 256) * 256 + wd; end
                        end
                        m_ptr[ctl] = 1 - m_ptr[ctl];
                    end
                    2: m_mk[c2] = (wd / 4) % 2;
                    3: m_md[c2] = wd / 4;
                    4: m_ptr[ctl] = 0;
                    5: m_pg[ch] = wd;
                    default: ;
                endcase
            end else if (io_rd && kind == 1) m_ptr[ctl] = 1 - m_ptr[ctl];
            for (int c = 0; c < 8; c++) begin
                if (xfer_step[c] && om[c] == 0 && (omd[c] / 16) != 3 && wrac[c] == 0) begin
                    m_ca[c] = (m_ca[c] + 1) % 65536;
                    if (m_cc[c] == 0) begin m_cc[c] = 65535; m_tc[c] = 1; m_mk[c] = 1; end
                    else m_cc[c] = m_cc[c] - 1;
                end
            end
        end
    end

    function automatic int exp_rdata();
        int kind, ch, isc, ctl, v;
        if (!io_rd) return 0;
        decode(int'(io_addr), kind, ch, isc, ctl);
        if (kind == 1) begin
            v = isc ? m_cc[ch] : m_ca[ch];
            return m_ptr[ctl] ? v / 256 : v % 256;
        end
        if (kind == 5) return m_pg[ch];
        return 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare every output each cycle, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 8; c++) begin
                int ep, el;
                ep = (c < 4) ? m_pg[c] * 65536 + m_ba[c] : (m_pg[c] / 2) * 131072 + m_ba[c] * 2;
                el = (c < 4) ? m_bc[c] + 1 : (m_bc[c] + 1) * 2;
                chk($sformatf("R2 R3 R4 R5 phys ch%0d", c), int'(ch_phys_addr[c*24 +: 24]), ep);
                chk($sformatf("R6 len ch%0d", c), int'(ch_len[c*18 +: 18]), el);
                chk($sformatf("R8 to_mem ch%0d", c), int'(ch_to_mem[c]), int'((m_md[c] % 4) == 1));
                chk($sformatf("R8 cascade ch%0d", c), int'(ch_cascade[c]), int'((m_md[c] / 16) == 3));
                chk($sformatf("R7 R11 enabled ch%0d", c), int'(ch_enabled[c]), 1 - m_mk[c]);
                chk($sformatf("R10 tc ch%0d", c), int'(ch_tc[c]), m_tc[c]);
            end
            chk("R12 R9 rdata", int'(io_rdata), exp_rdata());
        end
    end

    // ---------------- stimulus tasks (entered at posedge+1) ----------------
    task automatic wr(input int a, input int d);
        io_addr = 8'(a); io_wdata = 8'(d); io_wr = 1'b1;
        @(posedge clk); #1; io_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        io_addr = 8'(a); io_rd = 1'b1;
        @(posedge clk); #1; io_rd = 1'b0;
    endtask

    task automatic stp(input int m);
        xfer_step = 8'(m);
        @(posedge clk); #1; xfer_step = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(0);
        @(posedge clk); @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 enabled", int'(ch_enabled), 0);
        chk("R1 tc", int'(ch_tc), 0);
        chk("R1 phys", int'(ch_phys_addr[23:0]), 0);
        @(posedge clk); #1;

        // R2 R3 R4 R8 R7: byte channel 1
        wr(BB + 12, 0);
        wr(BB + 2, 'h34); wr(BB + 2, 'h12);
        wr(BB + 3, 'h03); wr(BB + 3, 'h00);
        wr('h83, 'h05);
        wr(BB + 11, 'h45);
        wr(BB + 10, 'h01);
        // R9 R10: four steps, last one wraps count
        stp('h02); stp('h02); stp('h02); stp('h02);
        idle(1);
        chk("R10 masked after tc", int'(ch_enabled[1]), 0);
        // R12: current count reads 0xFFFF, current address 0x1238
        rd(BB + 3); rd(BB + 3); rd(BB + 2); rd(BB + 2);

        // word channel 5
        wr(WB + 24, 0);
        wr(WB + 4, 'h00); wr(WB + 4, 'h80);
        wr(WB + 6, 'h01); wr(WB + 6, 'h00);
        wr('h8B, 'h03);
        wr(WB + 22, 'h49);
        wr(WB + 20, 'h01);
        chk("R5 word phys", int'(ch_phys_addr[5*24 +: 24]), 'h030000);
        stp('h20); stp('h20);
        idle(1);

        // R9: address wrap on channel 2 without page carry
        wr('h81, 'h07);
        wr(BB + 4, 'hFF); wr(BB + 4, 'hFF);
        wr(BB + 5, 'h02); wr(BB + 5, 'h00);
        wr(BB + 10, 'h02);
        stp('h04);
        rd(BB + 4); rd(BB + 4);
        // R11: step together with a count write is dropped
        io_addr = 8'(BB + 5); io_wdata = 8'h09; io_wr = 1'b1; xfer_step = 8'h04;
        @(posedge clk); #1; io_wr = 1'b0; xfer_step = '0;
        wr(BB + 12, 0);
        // R11: masked channel 3 ignores steps
        stp('h08);
        // R7: mask channel 2 with bit 2
        wr(BB + 10, 'h06);
        stp('h04);
        // R8 R11: cascade on channel 0 ignores steps
        wr(BB + 11, 'hC0); wr(BB + 10, 'h00); stp('h01);
        // R2: odd word address and unmapped read have no effect
        wr(WB + 1, 'h55); rd('h20); rd(WB + 4); rd(WB + 4);
        // R3: pointers of the two controllers are independent
        wr(BB + 12, 0); wr(WB + 24, 0);
        wr(BB + 6, 'h11); wr(WB + 8, 'h22); wr(BB + 6, 'h33); wr(WB + 8, 'h44);
        rd('h82);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r, a;
            r = $urandom_range(0, 9);
            case ($urandom_range(0, 4))
                0: a = BB + $urandom_range(0, 15);
                1: a = WB + $urandom_range(0, 31);
                2: a = pports[$urandom_range(0, 7)];
                3: a = BB + 10 + (($urandom_range(0, 1)) * (WB - BB + 10));
                default: a = $urandom_range(0, 255);
            endcase
            io_addr = 8'(a); io_wdata = 8'($urandom_range(0, 255));
            io_wr = (r < 4); io_rd = (r >= 4 && r < 6);
            xfer_step = 8'($urandom_range(0, 255));
            @(posedge clk); #1;
            io_wr = 1'b0; io_rd = 1'b0; xfer_step = '0;
        end
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule